// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a 16-bit converter that takes its code over a serial line. A slow serial clock, a data bit, two active-low enables and an active-low clear arrive from outside the chip. They are sampled by a fast system clock through two-flop synchronizers. A rising edge of the synchronized serial clock is detected and used as a one-cycle step.

On each step, the two enables pick one of four actions:
- shift a bit into the input register, MSB first;
- copy the input register into the output latch;
- do nothing;
- shift with the latch following the input register (two-wire mode).

The output latch drives the straight-binary converter code. The top bit of the input register leaves on a cascade pin, so devices can be daisy-chained on one bit stream. The clear zeroes both registers and overrides every other input.

All pins are plain level signals with no valid/ready handshake. The serial source cannot be stalled, so the block applies no back-pressure. The serial timing limits (period of at least 100 ns, phases of at least 50 ns) must therefore span at least two system cycles per phase, so that every edge is seen.

Top module: `sdac_front`

## Requirements
- R1: While the system reset `rst_n` is low, and on the first cycle after it, `code_o` is 0x0000, `casc_o` is 0 and `code_upd_o` is 0.
- R2: The registers change only on a rising edge of the synchronized serial clock. A falling edge, or a serial clock held high for many cycles, produces no further action. The one exception is the clear, which acts on any cycle.
- R3: With `shift_en_n` low and `load_en_n` high, each serial rising edge shifts `ser_data` into bit 0 of the input register and moves every bit up by one. After 16 edges the first bit sent sits in bit 15. `code_o` is unchanged.
- R4: With `shift_en_n` high and `load_en_n` low, a serial rising edge copies the input register into `code_o` and leaves the input register unchanged.
- R5: With both enables high, serial rising edges change neither `code_o` nor the input register.
- R6: With both enables low (two-wire mode), each edge shifts as in R3, and `code_o` takes the shifted register value on the same system cycle.
- R7: With `clear_n` low, both the input register and `code_o` become 0x0000, whatever the serial clock and enables do.
- R8: `casc_o` shows bit 15 of the input register. A word shifted in therefore leaves on `casc_o` MSB first during the next 16 shifts.
- R9: `code_upd_o` is high for exactly the cycles in which `code_o` differs from its value on the previous cycle.
- R10: An input change at a system clock edge takes effect on the registers at the third following system clock edge: two synchronizer stages, then the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| ser_clk | input | 1 | Asynchronous serial clock; rising edge is active |
| ser_data | input | 1 | Serial data bit, MSB first |
| shift_en_n | input | 1 | Active-low enable for shifting the input register |
| load_en_n | input | 1 | Active-low enable for updating the output latch |
| clear_n | input | 1 | Active-low clear of both registers |
| code_o | output | 16 | Converter code held in the output latch |
| casc_o | output | 1 | Cascade output: top bit of the input register |
| code_upd_o | output | 1 | One-cycle strobe when `code_o` changes |

## Verification
The bound checker tests on every cycle:
- what one step does in each of the four enable combinations;
- that nothing moves without a detected serial edge;
- that the clear zeroes both registers;
- that the cascade bit follows the register's second-highest bit;
- that the strobe matches a change of the code.

Only the bench's scenarios show the sequence-level effects. These are the MSB-first word placement after 16 edges, the latency through the synchronizers, and a long high phase counting as a single edge. They also cover a full word emerging on the cascade pin during the next word, and the two-wire mode exposing every partial value.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_SHIFT = 2'b01,
    ACT_LOAD  = 2'b10,
    ACT_BOTH  = 2'b11
  } act_e;

  function automatic act_e decode_act(input logic shift_n, input logic load_n);
    return act_e'({~load_n, ~shift_n});
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/sdac_rise.sv
module sdac_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sdac_dbuf.sv
module sdac_dbuf
  import sdac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         step,
  input  act_e         act,
  input  logic         din,
  output logic [W-1:0] shreg_o,
  output logic [W-1:0] code_o,
  output logic         upd_o
);
  logic [W-1:0] sh_q, sh_d, cd_q, cd_d;
  logic         upd_q;

  always_comb begin
    sh_d = sh_q;
    cd_d = cd_q;
    if (!clr_n) begin
      sh_d = '0;
      cd_d = '0;
    end else if (step) begin
      unique case (act)
        ACT_SHIFT: sh_d = {sh_q[W-2:0], din};
        ACT_LOAD:  cd_d = sh_q;
        ACT_BOTH: begin
          sh_d = {sh_q[W-2:0], din};
          cd_d = {sh_q[W-2:0], din};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cd_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cd_q  <= cd_d;
      upd_q <= (cd_d != cd_q);
    end
  end

  assign shreg_o = sh_q;
  assign code_o  = cd_q;
  assign upd_o   = upd_q;
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_data,
  input  logic         shift_en_n,
  input  logic         load_en_n,
  input  logic         clear_n,
  output logic [W-1:0] code_o,
  output logic         casc_o,
  output logic         code_upd_o
);
  localparam int CTRL_W = 5;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 5'b11100;

  logic [CTRL_W-1:0] raw_in, syn;
  logic              s_clk, s_data, s_sh_n, s_ld_n, s_clr_n;
  logic              step;
  act_e              act;
  logic [W-1:0]      shreg;

  assign raw_in = {clear_n, load_en_n, shift_en_n, ser_data, ser_clk};

  sdac_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn)
  );

  assign {s_clr_n, s_ld_n, s_sh_n, s_data, s_clk} = syn;

  sdac_rise rise_i (.clk(clk), .rst_n(rst_n), .lvl_i(s_clk), .rise_o(step));

  assign act = decode_act(s_sh_n, s_ld_n);

  sdac_dbuf #(.W(W)) dbuf_i (
    .clk(clk), .rst_n(rst_n), .clr_n(s_clr_n), .step(step), .act(act),
    .din(s_data), .shreg_o(shreg), .code_o(code_o), .upd_o(code_upd_o)
  );

  assign casc_o = shreg[W-1];
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step,
  input logic         s_clr_n,
  input logic         s_sh_n,
  input logic         s_ld_n,
  input logic         s_data,
  input logic [W-1:0] shreg,
  input logic [W-1:0] code_o,
  input logic         casc_o,
  input logic         code_upd_o
);
  assert_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && s_clr_n) |=> ($stable(code_o) && $stable(shreg)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s_clr_n && !s_sh_n && s_ld_n) |=>
      (shreg == {$past(shreg[W-2:0]), $past(s_data)} && $stable(code_o)));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s_clr_n && s_sh_n && !s_ld_n) |=>
      (code_o == $past(shreg) && $stable(shreg)));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s_clr_n && s_sh_n && s_ld_n) |=> ($stable(code_o) && $stable(shreg)));

  assert_twowire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s_clr_n && !s_sh_n && !s_ld_n) |=> (code_o == shreg));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_clr_n |=> (code_o == '0 && shreg == '0));

  assert_casc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s_clr_n && !s_sh_n) |=> (casc_o == $past(shreg[W-2])));

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (code_upd_o == (code_o != $past(code_o))));
endmodule

bind sdac_front sdac_front_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .step(step), .s_clr_n(s_clr_n), .s_sh_n(s_sh_n),
  .s_ld_n(s_ld_n), .s_data(s_data), .shreg(shreg), .code_o(code_o),
  .casc_o(casc_o), .code_upd_o(code_upd_o)
);

// File: tb/sdac_front_tb.sv
module sdac_front_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0;
  logic shift_en_n = 1'b1, load_en_n = 1'b1, clear_n = 1'b1;
  logic [W-1:0] code_o;
  logic casc_o, code_upd_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sdac_front dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .shift_en_n(shift_en_n), .load_en_n(load_en_n), .clear_n(clear_n),
    .code_o(code_o), .casc_o(casc_o), .code_upd_o(code_upd_o)
  );

  // Behavioural reference: inputs delayed two cycles, edge taken from the delayed clock.
  logic [4:0] q_in [$];
  logic [4:0] dly;
  logic prev_clk = 1'b0;
  logic [W-1:0] m_sh = '0, m_code = '0, m_old;
  logic m_upd = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_in = {5'b11100, 5'b11100};
      prev_clk = 1'b0; m_sh = '0; m_code = '0; m_upd = 1'b0;
    end else begin
      dly = q_in[0];
      m_old = m_code;
      if (!dly[4]) begin
        m_sh = '0; m_code = '0;
      end else if (dly[0] && !prev_clk) begin
        if (!dly[2]) m_sh = {m_sh[W-2:0], dly[1]};
        if (!dly[3]) m_code = m_sh;
      end
      m_upd = (m_code != m_old);
      prev_clk = dly[0];
      void'(q_in.pop_front());
      q_in.push_back({clear_n, load_en_n, shift_en_n, ser_data, ser_clk});
    end
  end

  always @(posedge clk) begin
    #2;
    cyc++;
    n_cmp++;
    if (code_o !== m_code || casc_o !== m_sh[W-1] || code_upd_o !== m_upd) begin
      n_bad++;
      $display("FAIL %s cycle %0d: code/casc/upd act %h/%b/%b exp %h/%b/%b", cur_req, cyc,
               code_o, casc_o, code_upd_o, m_code, m_sh[W-1], m_upd);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spulse(logic d);
    ser_data = d;
    idle(2);
    ser_clk = 1'b1;
    idle(4);
    ser_clk = 1'b0;
    idle(4);
  endtask

  task automatic send(logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) spulse(w[i]);
  endtask

  task automatic mode(logic sh_n, logic ld_n);
    shift_en_n = sh_n; load_en_n = ld_n;
    idle(3);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none

    // R1 reset state
    idle(3);
    chk("R1 code in reset", code_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {code_o, casc_o, code_upd_o}, 0);

    // R3 MSB-first shift, latch holds
    cur_req = "R3";
    mode(1'b0, 1'b1);
    send(16'hA5C3);
    chk("R3 latch untouched while shifting", code_o, 0);
    chk("R8 cascade shows top bit", casc_o, 1);

    // R4 load without shift; R9 strobe exactly once
    cur_req = "R4";
    mode(1'b1, 1'b0);
    ser_data = 1'b0; idle(2); ser_clk = 1'b1;
    begin
      int pulses = 0;
      repeat (6) begin @(negedge clk); if (code_upd_o) pulses++; end
      ser_clk = 1'b0;
      repeat (4) begin @(negedge clk); if (code_upd_o) pulses++; end
      chk("R4 word placed MSB first", code_o, 16'hA5C3);
      chk("R9 single strobe per change", pulses, 1);
    end
    // R9: reload with same value gives no strobe
    cur_req = "R9";
    begin
      int pulses = 0;
      ser_clk = 1'b1;
      repeat (6) begin @(negedge clk); if (code_upd_o) pulses++; end
      ser_clk = 1'b0;
      repeat (4) begin @(negedge clk); if (code_upd_o) pulses++; end
      chk("R9 no strobe when code unchanged", pulses, 0);
      chk("R4 input register not shifted by load", casc_o, 1);
    end

    // R10 latency: rise seen at third edge after input change
    cur_req = "R10";
    mode(1'b0, 1'b0);
    ser_data = 1'b1; idle(2);
    ser_clk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 no action after two edges", code_o, 16'hA5C3);
    @(negedge clk);
    chk("R10 action on third edge", code_o, 16'h4B87);
    ser_clk = 1'b0; idle(4);

    // R2 long high phase counts once
    cur_req = "R2";
    ser_data = 1'b0; idle(2);
    ser_clk = 1'b1; idle(40);
    ser_data = 1'b1; idle(10);
    ser_clk = 1'b0; idle(6);
    chk("R2 one shift per long high phase", code_o, 16'h970E);

    // R5 both high: nothing
    cur_req = "R5";
    mode(1'b1, 1'b1);
    spulse(1'b1); spulse(1'b0); spulse(1'b1);
    chk("R5 code unchanged", code_o, 16'h970E);
    mode(1'b1, 1'b0);
    spulse(1'b0);
    chk("R5 input register unchanged", code_o, 16'h970E);

    // R6 two-wire: every partial value appears
    cur_req = "R6";
    mode(1'b0, 1'b0);
    begin
      logic [W-1:0] exp_v = 16'h970E;
      logic [W-1:0] w = 16'h1234;
      for (int i = W - 1; i >= 0; i--) begin
        spulse(w[i]);
        exp_v = {exp_v[W-2:0], w[i]};
        chk("R6 partial word on output", code_o, exp_v);
      end
    end

    // R8 cascade: previous word leaves MSB first
    cur_req = "R8";
    mode(1'b0, 1'b1);
    send(16'hC0DE);
    begin
      logic [W-1:0] got = '0;
      for (int i = W - 1; i >= 0; i--) begin
        got[i] = casc_o;
        spulse(1'b0);
      end
      chk("R8 cascaded word", got, 16'hC0DE);
    end

    // R7 clear overrides activity
    cur_req = "R7";
    send(16'hFFFF);
    mode(1'b0, 1'b0);
    clear_n = 1'b0;
    spulse(1'b1); spulse(1'b1);
    chk("R7 code cleared", code_o, 0);
    chk("R7 cascade cleared", casc_o, 0);
    clear_n = 1'b1;
    mode(1'b1, 1'b0);
    spulse(1'b1);
    chk("R7 input register cleared", code_o, 0);

    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule